// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits on the memory side of a small shared-memory multiprocessor. For each memory block it holds a directory entry with one presence bit per cache and one flag. The flag marks a block whose only copy is a modified, private one held by a single cache. Caches send three kinds of request: read miss, write miss and write hit. A write hit asks for private ownership of a block the cache already holds.

For each request the controller first looks up the entry. It then sends a fetch or an invalidate command to the caches that must act on it. It counts their acknowledgements, which carry the owner's data back to memory when needed. It rewrites the entry and finally replies to the requester. Requests are served one at a time.

Request and reply channels follow valid/ready rules:
- **Requests:** a cache raises `req_valid` and holds its op and address stable until it sees `req_ready` high at a clock edge.
- **Replies:** `rsp_valid`, `rsp_kind` and `rsp_data` stay stable until the requester returns `rsp_ready`.
- **Commands:** the command pins are plain single-cycle pulses.
- **Acknowledgements:** these are single-cycle pulses, with the data beside them.

The memory port has a combinational read and a write that takes effect at the clock edge.

Top module: `fullmap_dir_ctrl`

## Requirements
- R1: After reset every directory entry has no cache present and its modified flag clear. No `req_ready`, `rsp_valid`, `cmd_valid` or `mem_we` is high while reset is held.
- R2: Read miss (op 0) on an unmodified entry:
  - no command is sent;
  - the reply (kind 0) carries the memory word;
  - the requester's presence bit is added.
- R3: Read miss on a modified entry:
  - a fetch (cmd_op 1) goes to the owner only;
  - the owner's acknowledgement data is written to memory and returned to the requester;
  - the entry then lists owner and requester as present and is no longer modified.
- R4: Write miss (op 1):
  - an invalidate (cmd_op 0) goes to every present cache except the requester;
  - if the entry was modified, the owner's acknowledgement data is written to memory;
  - the reply (kind 0) carries the memory word.
- R5: Write hit (op 2): an invalidate goes to every present cache except the requester, and the reply has kind 1 (grant, data not meaningful).
- R6: After any write request completes, the entry lists only the writer and is marked modified. A following read miss from another cache therefore sends a fetch to the writer alone.
- R7: The reply is not raised until every commanded cache has acknowledged. Acknowledgements may arrive in any order, in one cycle or spread over many cycles.
- R8: Only one request is in service at a time, and at most one `req_ready` is high.
  - Waiting requests are taken in order of arrival.
  - Requests that arrive in the same cycle are taken lowest port index first.
- R9: A reply that is not accepted keeps `rsp_valid` and its payload unchanged until `rsp_ready` is seen.
- R10: Commands are driven for exactly one cycle: the cycle after the request is accepted. `cmd_addr` carries the request's address in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Request valid, one bit per cache |
| req_ready | output | NPROC | Request accepted, one bit per cache |
| req_op | input | 2*NPROC | Per-cache op: 0 read miss, 1 write miss, 2 write hit |
| req_addr | input | NPROC*AW | Per-cache block index |
| cmd_valid | output | NPROC | Command pulse to each targeted cache |
| cmd_op | output | 1 | 0 invalidate, 1 fetch |
| cmd_addr | output | AW | Block index of the command |
| ack_valid | input | NPROC | Acknowledgement pulse from each cache |
| ack_data | input | NPROC*DW | Block data sent with each acknowledgement |
| rsp_valid | output | NPROC | Reply valid to the requester |
| rsp_ready | input | NPROC | Reply accepted by each cache |
| rsp_kind | output | 1 | 0 data reply, 1 ownership grant |
| rsp_data | output | DW | Block data of a data reply |
| mem_addr | output | AW | Memory block index |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (combinational) |

## Verification
The bench builds the block with its default parameters: four caches, sixteen entries and 32-bit data. With four caches every sharer pattern can occur, from no sharers up to three other caches to invalidate. Random traffic is concentrated on four entries so that sharing, modified owners and fetch-then-invalidate chains recur often. The acknowledgement counter is driven by every subset size the directory can present, with acknowledgements spread randomly over cycles. Directed runs with three and two waiting caches cover arrival order and same-cycle ties in the arbiter.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  typedef enum logic [1:0] {
    OP_RDMISS = 2'd0,
    OP_WRMISS = 2'd1,
    OP_WRHIT  = 2'd2
  } req_op_e;

  typedef enum logic {
    CMD_INV   = 1'b0,
    CMD_FETCH = 1'b1
  } cmd_op_e;

  typedef enum logic {
    RSP_DATA  = 1'b0,
    RSP_GRANT = 1'b1
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NOTIFY,
    ST_COLLECT,
    ST_REPLY
  } seq_state_e;
endpackage

// File: rtl/fmd_age_arb.sv
module fmd_age_arb #(
  parameter int NP = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req_valid,
  input  logic          enable,
  output logic [NP-1:0] grant
);
  logic [NP-1:0] seen_q;
  logic [NP-1:0] older_q [NP];
  logic [NP-1:0] arrive;
  logic [NP-1:0] win;

  assign arrive = req_valid & ~seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
      for (int i = 0; i < NP; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (grant[i]) seen_q[i] <= 1'b0;
        else if (arrive[i]) seen_q[i] <= 1'b1;
        for (int j = 0; j < NP; j++) begin
          if (i != j) begin
            if (arrive[i])
              older_q[i][j] <= !seen_q[j] && !(arrive[j] && (j < i));
            else if (arrive[j])
              older_q[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      win[i] = seen_q[i];
      for (int j = 0; j < NP; j++)
        if ((i != j) && seen_q[j] && !older_q[i][j]) win[i] = 1'b0;
    end
    grant = enable ? win : '0;
  end

  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_has_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (|(grant & req_valid)));
endmodule

// File: rtl/fmd_dir_store.sv
module fmd_dir_store #(
  parameter int NP   = 4,
  parameter int NENT = 16,
  parameter int AW   = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [NP-1:0] rd_pres,
  output logic          rd_dirty,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [NP-1:0] wr_pres,
  input  logic          wr_dirty
);
  logic [NP-1:0]   pres_q [NENT];
  logic [NENT-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) pres_q[e] <= '0;
      dirty_q <= '0;
    end else if (we) begin
      pres_q[wr_addr]  <= wr_pres;
      dirty_q[wr_addr] <= wr_dirty;
    end
  end

  assign rd_pres  = pres_q[rd_addr];
  assign rd_dirty = dirty_q[rd_addr];

  p_excl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_dirty) |-> $onehot(wr_pres));
  p_modified_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> $onehot(rd_pres));
endmodule

// File: rtl/fmd_ack_ctr.sv
module fmd_ack_ctr #(
  parameter int NP = 4,
  localparam int CW = $clog2(NP + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NP-1:0] load_mask,
  input  logic [NP-1:0] ack,
  output logic          done,
  output logic [NP-1:0] hit
);
  logic [CW-1:0] cnt_q;
  logic [NP-1:0] pend_q;

  function automatic logic [CW-1:0] pop(input logic [NP-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NP; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  assign hit  = ack & pend_q;
  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (load) begin
      cnt_q  <= pop(load_mask);
      pend_q <= load_mask;
    end else begin
      cnt_q  <= cnt_q - pop(hit);
      pend_q <= pend_q & ~ack;
    end
  end

  p_count_tracks_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == pop(pend_q));
endmodule

// File: rtl/fullmap_dir_ctrl.sv
module fullmap_dir_ctrl
  import fmd_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NENTRY = 16,
  parameter int DW     = 32,
  localparam int AW    = $clog2(NENTRY)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPROC-1:0]    req_valid,
  output logic [NPROC-1:0]    req_ready,
  input  logic [2*NPROC-1:0]  req_op,
  input  logic [NPROC*AW-1:0] req_addr,
  output logic [NPROC-1:0]    cmd_valid,
  output logic                cmd_op,
  output logic [AW-1:0]       cmd_addr,
  input  logic [NPROC-1:0]    ack_valid,
  input  logic [NPROC*DW-1:0] ack_data,
  output logic [NPROC-1:0]    rsp_valid,
  input  logic [NPROC-1:0]    rsp_ready,
  output logic                rsp_kind,
  output logic [DW-1:0]       rsp_data,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_we,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata
);
  seq_state_e       state;
  req_op_e          cur_op;
  logic [NPROC-1:0] grant, cur_sel, cur_pres, tgt, ack_hit, rd_pres, wr_pres, ack_gated;
  logic [AW-1:0]    cur_addr, win_addr;
  logic [1:0]       win_op;
  logic             cur_dirty, rd_dirty, accept, arb_en, ctr_done, is_rd, dir_we, ctr_load;
  logic [DW-1:0]    owner_data;

  assign arb_en = (state == ST_IDLE);

  fmd_age_arb #(.NP(NPROC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .enable(arb_en), .grant(grant)
  );

  always_comb begin
    win_addr = '0;
    win_op   = '0;
    for (int i = 0; i < NPROC; i++)
      if (grant[i]) begin
        win_addr = win_addr | req_addr[i*AW +: AW];
        win_op   = win_op | req_op[2*i +: 2];
      end
  end

  assign accept    = |(grant & req_valid);
  assign req_ready = grant;
  assign is_rd     = (cur_op == OP_RDMISS);
  assign dir_we    = (state == ST_COLLECT) && ctr_done;
  assign wr_pres   = is_rd ? (cur_pres | cur_sel) : cur_sel;

  fmd_dir_store #(.NP(NPROC), .NENT(NENTRY), .AW(AW)) u_dir (
    .clk(clk), .rst_n(rst_n), .rd_addr(win_addr), .rd_pres(rd_pres), .rd_dirty(rd_dirty),
    .we(dir_we), .wr_addr(cur_addr), .wr_pres(wr_pres), .wr_dirty(!is_rd)
  );

  // Caches that must act: every other holder; a clean read needs nobody.
  always_comb begin
    tgt = cur_pres & ~cur_sel;
    if (is_rd && !cur_dirty) tgt = '0;
  end

  assign ctr_load  = (state == ST_NOTIFY);
  assign ack_gated = (state == ST_COLLECT) ? ack_valid : '0;

  fmd_ack_ctr #(.NP(NPROC)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_mask(tgt),
    .ack(ack_gated), .done(ctr_done), .hit(ack_hit)
  );

  always_comb begin
    owner_data = '0;
    for (int i = 0; i < NPROC; i++)
      if (ack_hit[i]) owner_data = owner_data | ack_data[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_sel   <= '0;
      cur_op    <= OP_RDMISS;
      cur_addr  <= '0;
      cur_pres  <= '0;
      cur_dirty <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          cur_sel   <= grant;
          cur_op    <= req_op_e'(win_op);
          cur_addr  <= win_addr;
          cur_pres  <= rd_pres;
          cur_dirty <= rd_dirty;
          state     <= ST_NOTIFY;
        end
        ST_NOTIFY:  state <= ST_COLLECT;
        ST_COLLECT: if (ctr_done) state <= ST_REPLY;
        ST_REPLY:   if (|(rsp_ready & cur_sel)) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid = (state == ST_NOTIFY) ? tgt : '0;
  assign cmd_op    = is_rd ? CMD_FETCH : CMD_INV;
  assign cmd_addr  = cur_addr;
  assign mem_addr  = cur_addr;
  assign mem_we    = (state == ST_COLLECT) && cur_dirty && (|ack_hit);
  assign mem_wdata = owner_data;
  assign rsp_valid = (state == ST_REPLY) ? cur_sel : '0;
  assign rsp_kind  = (cur_op == OP_WRHIT) ? RSP_GRANT : RSP_DATA;
  assign rsp_data  = mem_rdata;

  p_reply_after_acks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> ctr_done);
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_valid) && !(|(rsp_valid & rsp_ready))) |=> (rsp_valid == $past(rsp_valid)));
  p_cmd_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_valid) |=> (cmd_valid == '0));
  p_fetch_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_valid) && cmd_op) |-> $onehot(cmd_valid));
endmodule

// File: tb/fullmap_dir_ctrl_bench.sv
`timescale 1ns/1ps
module fullmap_dir_ctrl_bench;
  import fmd_pkg::*;
  localparam int NP = 4, NENT = 16, DW = 32, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0, req_ready, cmd_valid, ack_valid = '0, rsp_valid, rsp_ready = '0;
  logic [2*NP-1:0] req_op = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] ack_data = '0;
  logic cmd_op, rsp_kind, mem_we;
  logic [AW-1:0] cmd_addr, mem_addr;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;

  logic [DW-1:0] mem [NENT];
  logic [DW-1:0] ref_mem [NENT];
  logic [NP-1:0] ref_pres [NENT];
  logic          ref_dirty [NENT];
  logic [DW-1:0] cache_val [NP];
  int checks = 0, fails = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  fullmap_dir_ctrl #(.NPROC(NP), .NENTRY(NENT), .DW(DW)) u_fullmap_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .ack_valid(ack_valid), .ack_data(ack_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  task automatic run_req(input int p, input req_op_e op, input int a, input string tag);
    logic [NP-1:0] bm, tgt, rem, sub;
    bit acc;
    int guard, stall, owner;
    bm = '0; bm[p] = 1'b1;
    tgt = ref_pres[a] & ~bm;
    if (op == OP_RDMISS && !ref_dirty[a]) tgt = '0;
    owner = 0;
    for (int i = 0; i < NP; i++) if (tgt[i]) owner = i;
    for (int i = 0; i < NP; i++) begin
      cache_val[i] = $urandom;
      ack_data[i*DW +: DW] = cache_val[i];
    end
    rsp_ready[p] = 1'b0;
    req_op[2*p +: 2] = op;
    req_addr[AW*p +: AW] = AW'(a);
    req_valid[p] = 1'b1;
    acc = 0; guard = 0;
    while (!acc && guard < 40) begin
      @(negedge clk); guard++;
      if (req_ready[p]) acc = 1;
    end
    chk(acc, {tag, " R8 request accepted"}, 64'(acc), 64'd1);
    @(negedge clk);
    req_valid[p] = 1'b0;
    // R10: command pulse in the cycle after acceptance
    chk(cmd_valid == tgt, {tag, " R10 command targets"}, 64'(cmd_valid), 64'(tgt));
    if (tgt != '0) begin
      chk(cmd_op == (op == OP_RDMISS), {tag, " R10 command op"}, 64'(cmd_op), 64'(op == OP_RDMISS));
      chk(cmd_addr == AW'(a), {tag, " R10 command addr"}, 64'(cmd_addr), 64'(a));
    end
    if (ref_dirty[a] && tgt != '0) ref_mem[a] = cache_val[owner];
    rem = tgt;
    while (rem != '0) begin
      @(negedge clk);
      ack_valid = '0;
      chk(rsp_valid == '0, {tag, " R7 reply before last ack"}, 64'(rsp_valid), 64'd0);
      sub = rem & NP'($urandom);
      ack_valid = sub;
      rem = rem & ~sub;
    end
    @(negedge clk);
    ack_valid = '0;
    chk(rsp_valid == '0, {tag, " R7 reply too early"}, 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(rsp_valid == bm, {tag, " reply to requester"}, 64'(rsp_valid), 64'(bm));
    chk(rsp_kind == (op == OP_WRHIT), {tag, " reply kind"}, 64'(rsp_kind), 64'(op == OP_WRHIT));
    if (op != OP_WRHIT)
      chk(rsp_data == ref_mem[a], {tag, " reply data"}, 64'(rsp_data), 64'(ref_mem[a]));
    stall = $urandom % 3;
    repeat (stall) begin
      @(negedge clk);
      chk(rsp_valid == bm, {tag, " R9 reply held"}, 64'(rsp_valid), 64'(bm));
    end
    rsp_ready[p] = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0, {tag, " R9 reply released"}, 64'(rsp_valid), 64'd0);
    rsp_ready[p] = 1'b0;
    if (op == OP_RDMISS) begin
      ref_pres[a] = ref_pres[a] | bm;
      ref_dirty[a] = 1'b0;
    end else begin
      ref_pres[a] = bm;
      ref_dirty[a] = 1'b1;
    end
  endtask

  task automatic arb_seq(input int t[NP], input int want[NP], input int nwant, input int a);
    int order[NP];
    int n;
    bit drop[NP];
    n = 0;
    for (int i = 0; i < NP; i++) begin drop[i] = 0; order[i] = -1; end
    rsp_ready = '1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      for (int i = 0; i < NP; i++) if (drop[i]) begin req_valid[i] = 1'b0; drop[i] = 0; end
      for (int i = 0; i < NP; i++)
        if (req_ready[i] && req_valid[i]) begin
          if (n < NP) order[n] = i;
          n++;
          drop[i] = 1;
        end
      for (int i = 0; i < NP; i++)
        if (t[i] == c) begin
          req_op[2*i +: 2] = OP_RDMISS;
          req_addr[AW*i +: AW] = AW'(a);
          req_valid[i] = 1'b1;
        end
    end
    rsp_ready = '0;
    chk(n == nwant, "R8 number of grants", 64'(n), 64'(nwant));
    for (int k = 0; k < nwant; k++) begin
      chk(order[k] == want[k], "R8 service order", 64'(order[k]), 64'(want[k]));
      ref_pres[a][want[k]] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7: actual hung expected completion");
    report();
    $finish;
  end

  initial begin
    int p, a;
    req_op_e op;
    void'($urandom(32'd4131));
    for (int e = 0; e < NENT; e++) begin
      mem[e] = 32'hA500_0000 + 32'(e * 17);
      ref_mem[e] = mem[e];
      ref_pres[e] = '0;
      ref_dirty[e] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1: quiet outputs while reset is held
    chk(req_ready == '0 && rsp_valid == '0, "R1 ready/reply in reset", 64'({req_ready, rsp_valid}), 64'd0);
    chk(cmd_valid == '0 && !mem_we, "R1 command/memory in reset", 64'({cmd_valid, mem_we}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == '0 && rsp_valid == '0 && cmd_valid == '0, "R1 idle after reset",
        64'({req_ready, rsp_valid, cmd_valid}), 64'd0);

    run_req(0, OP_RDMISS, 5, "R1 R2 clean read, empty entry");
    run_req(2, OP_RDMISS, 5, "R2 second sharer");
    run_req(1, OP_WRMISS, 5, "R4 write miss invalidates two");
    run_req(3, OP_RDMISS, 5, "R3 R6 fetch from writer");
    run_req(3, OP_WRHIT, 5, "R5 R3 write hit invalidates former owner");
    run_req(2, OP_RDMISS, 5, "R6 fetch from write-hit owner");
    run_req(0, OP_WRMISS, 5, "R4 write miss with two sharers");
    run_req(0, OP_WRHIT, 5, "R5 owner write hit, no commands");
    run_req(1, OP_WRMISS, 5, "R4 write miss takes modified data");
    for (int q = 0; q < NP; q++) run_req(q, OP_RDMISS, 7, "R2 fill all sharers");
    run_req(2, OP_WRHIT, 7, "R5 R7 three invalidates");

    arb_seq('{-1, 0, -1, 0}, '{1, 3, 0, 0}, 2, 9);
    arb_seq('{2, -1, 1, 0}, '{3, 2, 0, 0}, 3, 10);

    for (int k = 0; k < 250; k++) begin
      p = int'($urandom % NP);
      a = ($urandom % 4 == 0) ? int'($urandom % NENT) : int'($urandom % 4);
      op = req_op_e'($urandom % 3);
      run_req(p, op, a, "R7 random traffic");
    end
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule